// File: doc/BRIEF.md
# Demodulator Acquisition Control FSM

This block controls how a digital receiver starts up and how it is supervised once running. It tracks three phases. In channel acquisition the loops are still settling. In equalizer training the adaptive equalizer converges on the training sequences. In normal operation decoded data flows.

Two flags come from the front end: a segment-sync lock flag, and a strobed 16-bit mean-square-error figure, reported once per training sequence. The block compares that figure against a programmable threshold. From these inputs it drives four things: a reset that holds the decoding back-end idle during training, an equalizer-lock indicator, a 2-bit state value for register readback, and a one-cycle equalizer-restart pulse.

The restart pulse comes from a supervision timer that runs in normal operation. If the error figure stays above the threshold for a parameterised number of cycles, the timer pulses the equalizer restart. The machine stays in normal operation when this happens.

The MSE input is a valid-only stream. The block accepts every strobed sample in the cycle it arrives and never applies back-pressure, so the port has no ready signal. The lock flag, the threshold and all outputs are plain level signals.

Top module: `demod_acq_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, the state is 0 (acquisition) with `backend_rst_o`, `eq_lock_o` and `eq_restart_o` all low until a clock edge moves the machine on.
- R2: A clock edge that samples `seg_lock_i` low puts the machine in state 0, whatever state it was in.
- R3: In state 0, a clock edge that samples `seg_lock_i` high moves the machine to state 1 (training).
- R4: In state 1 the machine moves to state 2 (normal) only on an edge where `mse_valid_i` is high and `mse_i` is strictly less than `mse_thr_i`. A sample equal to or above the threshold leaves it in state 1.
- R5: `backend_rst_o` is high exactly when the state is 1.
- R6: `eq_lock_o` is high exactly when the state is 2.
- R7: In state 2 with lock held, if TIMEOUT_CYC consecutive edges pass without a strobed sample at or below the threshold, `eq_restart_o` goes high for exactly one cycle. The state remains 2.
- R8: The supervision count returns to zero on any strobed sample with `mse_i` less than or equal to `mse_thr_i`, and after each restart pulse. The next pulse therefore comes TIMEOUT_CYC edges after the clearing edge.
- R9: All MSE comparisons are unsigned, so 16'h8000 is above a threshold of 16'h7FFF.
- R10: An `mse_i` value presented with `mse_valid_i` low has no effect on the state or on the supervision count.
- R11: `state_o` encodes acquisition as 2'b00, training as 2'b01 and normal as 2'b10. It never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_lock_i | input | 1 | Segment-sync lock flag from the front end |
| mse_valid_i | input | 1 | Strobe qualifying `mse_i` |
| mse_i | input | MSE_W | Equalizer mean-square error of the latest training sequence |
| mse_thr_i | input | MSE_W | Programmable MSE threshold |
| backend_rst_o | output | 1 | Holds the decoding back-end in reset during training |
| eq_restart_o | output | 1 | One-cycle equalizer restart pulse |
| eq_lock_o | output | 1 | Equalizer locked (normal operation) |
| state_o | output | 2 | Current state for readback |

## Verification
Some properties are checked by assertions on every cycle:
- the state encoding stays legal;
- a lock drop always leads to acquisition;
- an acquiring machine with lock advances;
- training without a qualifying sample holds;
- the restart pulse is single-cycle and only occurs while locked;
- the supervision count stays within its window.

The exact timeout length, the counter clearing on a sample equal to the threshold, the unsigned comparison at the sign-bit boundary and the ignoring of unstrobed values can only be shown by the bench scenarios. The bench measures each of these against its own cycle-by-cycle expectation.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_ACQ   = 2'b00,
    ST_TRAIN = 2'b01,
    ST_NORM  = 2'b10
  } acq_state_e;
endpackage

// File: rtl/acq_mse_qual.sv
module acq_mse_qual #(
  parameter int MSE_W = 16
) (
  input  logic             vld_i,
  input  logic [MSE_W-1:0] val_i,
  input  logic [MSE_W-1:0] thr_i,
  output logic             below_o,   // strobed and strictly under threshold
  output logic             ok_o       // strobed and at or under threshold
);
  // unsigned compare on both paths
  always_comb begin
    below_o = vld_i && (val_i <  thr_i);
    ok_o    = vld_i && (val_i <= thr_i);
  end
endmodule

// File: rtl/acq_state_fsm.sv
module acq_state_fsm
  import acq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seg_lock_i,
  input  logic       mse_below_i,
  output acq_state_e state_o
);
  acq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!seg_lock_i) begin
      st_d = ST_ACQ;
    end else begin
      unique case (st_q)
        ST_ACQ:   st_d = ST_TRAIN;
        ST_TRAIN: if (mse_below_i) st_d = ST_NORM;
        ST_NORM:  st_d = ST_NORM;
        default:  st_d = ST_ACQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_ACQ;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 2'b11); // R11
  AST_LOSS_TO_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_lock_i |=> st_q == ST_ACQ); // R2
  AST_ACQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACQ && seg_lock_i) |=> st_q == ST_TRAIN); // R3
  AST_TRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRAIN && seg_lock_i && !mse_below_i) |=> st_q == ST_TRAIN); // R4
endmodule

// File: rtl/acq_eq_watchdog.sv
module acq_eq_watchdog #(
  parameter int TIMEOUT_CYC = 1076000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,    // normal operation with lock held
  input  logic mse_ok_i,    // strobed sample at or under threshold
  output logic restart_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fire;

  assign fire = active_i && !mse_ok_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      restart_o <= 1'b0;
    end else begin
      restart_o <= fire;
      if (active_i && !mse_ok_i && !fire) cnt_q <= cnt_q + 1'b1;
      else                                cnt_q <= '0;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R8
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mse_ok_i |=> cnt_q == '0); // R8
endmodule

// File: rtl/demod_acq_ctrl.sv
module demod_acq_ctrl
  import acq_pkg::*;
#(
  parameter int MSE_W       = 16,
  parameter int TIMEOUT_CYC = 1076000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_lock_i,
  input  logic             mse_valid_i,
  input  logic [MSE_W-1:0] mse_i,
  input  logic [MSE_W-1:0] mse_thr_i,
  output logic             backend_rst_o,
  output logic             eq_restart_o,
  output logic             eq_lock_o,
  output logic [1:0]       state_o
);
  logic       mse_below, mse_ok;
  acq_state_e st;

  acq_mse_qual #(.MSE_W(MSE_W)) u_qual (
    .vld_i   (mse_valid_i),
    .val_i   (mse_i),
    .thr_i   (mse_thr_i),
    .below_o (mse_below),
    .ok_o    (mse_ok)
  );

  acq_state_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .seg_lock_i  (seg_lock_i),
    .mse_below_i (mse_below),
    .state_o     (st)
  );

  acq_eq_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  ((st == ST_NORM) && seg_lock_i),
    .mse_ok_i  (mse_ok),
    .restart_o (eq_restart_o)
  );

  assign backend_rst_o = (st == ST_TRAIN);
  assign eq_lock_o     = (st == ST_NORM);
  assign state_o       = st;

  AST_RESTART_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    eq_restart_o |-> eq_lock_o); // R7
  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(backend_rst_o && eq_lock_o)); // R5
endmodule

// File: tb/demod_acq_ctrl_tb_top.sv
`timescale 1ns/1ps
module demod_acq_ctrl_tb_top;
  localparam int T = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_lock = 1'b0;
  logic        mse_vld = 1'b0;
  logic [15:0] mse = '0;
  logic [15:0] thr = 16'h1000;
  logic        be_rst, restart, eq_lock;
  logic [1:0]  st;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  demod_acq_ctrl #(.MSE_W(16), .TIMEOUT_CYC(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .seg_lock_i(seg_lock), .mse_valid_i(mse_vld),
    .mse_i(mse), .mse_thr_i(thr), .backend_rst_o(be_rst),
    .eq_restart_o(restart), .eq_lock_o(eq_lock), .state_o(st));

  // expected-value functions derived from the requirements
  function automatic logic [1:0] exp_next(logic [1:0] s, logic lk, logic v,
                                          logic [15:0] m, logic [15:0] th);
    if (!lk) return 2'd0;                       // R2
    if (s == 2'd0) return 2'd1;                 // R3
    if (s == 2'd1) return (v && m < th) ? 2'd2 : 2'd1; // R4 R9 R10
    return 2'd2;
  endfunction

  function automatic logic sample_ok(logic v, logic [15:0] m, logic [15:0] th);
    return v && (m <= th);                      // R8 R10
  endfunction

  logic [1:0] m_st;
  int         m_cnt;
  logic       m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 2'd0; m_cnt <= 0; m_pulse <= 1'b0;
    end else begin
      if (m_st == 2'd2 && seg_lock && !sample_ok(mse_vld, mse, thr)) begin
        m_pulse <= (m_cnt == T-1);
        m_cnt   <= (m_cnt == T-1) ? 0 : m_cnt + 1;
      end else begin
        m_pulse <= 1'b0;
        m_cnt   <= 0;
      end
      m_st <= exp_next(m_st, seg_lock, mse_vld, mse, thr);
    end
  end

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R11 state", st, m_st);
      check("R5 backend_rst", be_rst, m_st == 2'd1);
      check("R6 eq_lock", eq_lock, m_st == 2'd2);
      check("R7 restart", restart, m_pulse);
    end
  end

  initial begin
    #(4*200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    check("R1 reset state", st, 0);
    check("R1 reset eq_lock", eq_lock, 0);
    rst_n = 1'b1;
    step();
    check("R1 after release", st, 0);
    check("R1 restart low", restart, 0);

    // acquisition -> training
    seg_lock = 1'b1; step();
    check("R3 to training", st, 1);
    check("R5 backend held", be_rst, 1);

    // unsigned comparison at sign bit
    thr = 16'h7FFF; mse = 16'h8000; mse_vld = 1'b1; step();
    check("R9 unsigned compare", st, 1);
    // unstrobed small value ignored
    mse_vld = 1'b0; mse = 16'h0000; step();
    check("R10 unstrobed ignored", st, 1);
    // equal to threshold stays
    mse_vld = 1'b1; mse = 16'h7FFF; step();
    check("R4 equal stays", st, 1);
    mse = 16'h7FFE; step();
    check("R4 below exits", st, 2);
    check("R6 lock high", eq_lock, 1);
    check("R5 backend released", be_rst, 0);

    // timeout with no samples
    mse_vld = 1'b0;
    for (int i = 1; i <= T+1; i++) begin
      step();
      check("R7 timeout pulse", restart, i == T);
      check("R7 stays normal", st, 2);
    end
    // unstrobed good value must not clear the count; then strobed equal clears
    repeat (5) step();
    mse_vld = 1'b0; mse = 16'h0000; step();
    check("R10 no early clear", restart, 0);
    mse_vld = 1'b1; mse = thr; step();
    mse_vld = 1'b0;
    for (int i = 1; i <= T; i++) begin
      step();
      check("R8 cleared count", restart, i == T);
    end

    // lock loss from normal and from training
    seg_lock = 1'b0; step();
    check("R2 lock loss normal", st, 0);
    check("R6 lock low", eq_lock, 0);
    seg_lock = 1'b1; step();
    check("R3 reacquire", st, 1);
    seg_lock = 1'b0; step();
    check("R2 lock loss training", st, 0);

    // constrained random phases
    for (int ph = 0; ph < 30; ph++) begin
      bit bad = ph[0];
      thr = 16'($urandom % 16'hF000);
      for (int c = 0; c < 120; c++) begin
        seg_lock = ($urandom % 100) < 97;
        mse_vld  = ($urandom % 100) < 30;
        if (bad && ($urandom % 100) < 95)
          mse = thr + 16'd1 + 16'($urandom % 16'h0800);
        else
          mse = 16'($urandom);
        step();
      end
    end

    mse_vld = 1'b0;
    step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule